// File: doc/BRIEF.md
# Pseudo-SRAM Page-Mode Read Controller

This block sits on the host side of a 16-bit pseudo-SRAM and performs asynchronous reads with page mode. A request gives a start word address and a word count. The block then drives the memory's chip enable, output enable, address strobe, write enable, byte enables, clock pin and address bus. Each word comes back on a data port together with a one-cycle valid strobe.

The memory groups words into 16-word pages. The low four address bits choose a word inside the page. The first word read after chip enable falls needs the full random-access time. Later words in the same page need only the shorter page-access time, as long as page mode is enabled. Any move into a new page ends the window: chip enable goes high for one cycle and the next word pays the full access time again. The memory's refresh limits how long chip enable may stay low, so the block counts those cycles. It breaks the window before the next page access would overrun the limit.

All three times are parameters counted in clock cycles. The page-enable input stands for page mode having been configured in the memory. The memory's wait pin carries no meaning in this mode and is not connected.

Top module: `psram_page_reader`

## Requirements
- R1: After reset, and whenever no request is running, mem_ce_n and mem_oe_n are 1, rd_valid is 0 and req_ready is 1.
- R2: The first word of each chip-enable window has its address held, with mem_ce_n and mem_oe_n low, for exactly T_INIT cycles. mem_dq is sampled at the clock edge that ends the last of those cycles. The word is presented on rd_data in the following cycle with rd_valid high for that one cycle.
- R3: With page mode active, a word whose predecessor had a low nibble (address bits [3:0]) below 15 is read in the same window. Its address is held for T_PAGE cycles, so its rd_valid comes T_PAGE cycles after the previous one.
- R4: When the previous word had address bits [3:0] equal to 15, mem_ce_n and mem_oe_n go high for exactly one cycle. The next word then takes the full T_INIT access, so its rd_valid comes T_INIT+1 cycles after the previous one.
- R5: mem_ce_n is never low for more than T_CEMAX consecutive cycles. A same-page continuation is taken only if the cycles already spent low plus T_PAGE do not exceed T_CEMAX. Otherwise the window is broken as in R4.
- R6: When page_en is 0 at acceptance, every word uses the full T_INIT access and has a one-cycle chip-enable-high gap before it. page_en is sampled only when a request is accepted.
- R7: mem_clk is 0, mem_adv_n is 0, mem_we_n is 1, and mem_lb_n and mem_ub_n are 0 at all times.
- R8: In the cycle where rd_valid presents the last word of a request, mem_ce_n and mem_oe_n are already 1 and req_ready is 1.
- R9: A request is accepted only while req_ready is 1 and req_count is nonzero. A request with count 0, or one offered while busy, causes no memory activity and no output.
- R10: Words are returned in ascending address order, each address one above the previous. The address wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_en | input | 1 | Page mode configured in the memory; sampled on acceptance |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Start word address |
| req_count | input | CNT_W | Number of words to read |
| req_ready | output | 1 | Controller idle, able to accept a request |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| rd_data | output | DQ_W | Word read from the memory |
| mem_clk | output | 1 | Memory clock pin, held low |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_adv_n | output | 1 | Address-valid strobe, held low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, held high |
| mem_lb_n | output | 1 | Lower byte enable, held low |
| mem_ub_n | output | 1 | Upper byte enable, held low |
| mem_addr | output | ADDR_W | Word address to the memory |
| mem_dq | input | DQ_W | Data from the memory |

## Verification
The bench sweeps every start offset in a page against a range of counts. It predicts each word's arrival cycle with an arithmetic model of page crossings and the chip-enable budget. The memory model returns a poison word if the address has not been held for the access time its position requires. A controller that uses the short time on the first word of a window, or across a page edge, therefore returns wrong data; one that waits too long misses the predicted cycle. Long runs from offset 0 force a budget break in mid-page, and a controller that ignores the limit shows a chip-enable low run past T_CEMAX. A start near the top of the address space checks the wrap, and requests with count 0 or offered while busy check that nothing is launched.

// File: rtl/psram_rd_pkg.sv
package psram_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_GAP    = 2'd2
  } rd_state_e;
endpackage

// File: rtl/prd_access_timer.sv
// Countdown of the cycles an address must be held before data is sampled.
module prd_access_timer #(
  parameter int T_INIT = 7,
  parameter int T_PAGE = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load_init,
  input  logic load_page,
  output logic last
);
  localparam int TMAX = (T_INIT > T_PAGE) ? T_INIT : T_PAGE;
  localparam int TW   = $clog2(TMAX + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load_init) begin
      cnt <= TW'(T_INIT - 1);
    end else if (load_page) begin
      cnt <= TW'(T_PAGE - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/prd_ce_budget.sv
// Counts cycles spent with chip enable low in the current window and
// reports whether one more page access still fits the refresh limit.
module prd_ce_budget #(
  parameter int T_PAGE  = 3,
  parameter int T_CEMAX = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic room
);
  localparam int BW    = $clog2(T_CEMAX + 2);
  localparam int LIMIT = (T_CEMAX > T_PAGE) ? (T_CEMAX - T_PAGE) : 0;

  logic [BW-1:0] used;

  always_ff @(posedge clk) begin
    if (rst) begin
      used <= '0;
    end else if (start) begin
      used <= BW'(1);
    end else if (run && (used <= BW'(T_CEMAX))) begin
      used <= used + 1'b1;
    end
  end

  assign room = (T_CEMAX >= T_PAGE) && (used <= BW'(LIMIT));
endmodule

// File: rtl/prd_addr_seq.sv
// Holds the current word address and the words left in the request.
module prd_addr_seq #(
  parameter int ADDR_W = 23,
  parameter int CNT_W  = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  count,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last_word,
  output logic              page_end
);
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      left <= '0;
    end else if (load) begin
      addr <= start_addr;
      left <= count;
    end else if (step) begin
      addr <= addr + 1'b1;
      left <= left - 1'b1;
    end
  end

  assign last_word = (left == CNT_W'(1));
  assign page_end  = &addr[PAGE_W-1:0];
endmodule

// File: rtl/psram_page_reader.sv
module psram_page_reader
  import psram_rd_pkg::*;
#(
  parameter int ADDR_W  = 23,
  parameter int CNT_W   = 8,
  parameter int DQ_W    = 16,
  parameter int PAGE_W  = 4,
  parameter int T_INIT  = 9,
  parameter int T_PAGE  = 3,
  parameter int T_CEMAX = 400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              page_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic              mem_clk,
  output logic              mem_ce_n,
  output logic              mem_adv_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DQ_W-1:0]   mem_dq
);
  localparam int RW = $clog2(T_CEMAX + 2) + 1;

  rd_state_e state;
  logic      page_mode;
  logic      accept, acc_last, acc_done, last_word, page_end, room, keep_open;
  logic      load_init, load_page, seq_step;

  assign accept    = (state == ST_IDLE) && req_valid && (req_count != '0);
  assign acc_done  = (state == ST_ACCESS) && acc_last;
  assign keep_open = page_mode && !page_end && room;
  assign load_init = accept || (state == ST_GAP);
  assign load_page = acc_done && !last_word && keep_open;
  assign seq_step  = acc_done && !last_word;

  prd_access_timer #(.T_INIT(T_INIT), .T_PAGE(T_PAGE)) u_timer (
    .clk(clk), .rst(rst), .load_init(load_init), .load_page(load_page),
    .last(acc_last)
  );

  prd_ce_budget #(.T_PAGE(T_PAGE), .T_CEMAX(T_CEMAX)) u_budget (
    .clk(clk), .rst(rst), .start(load_init), .run(state == ST_ACCESS),
    .room(room)
  );

  prd_addr_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_seq (
    .clk(clk), .rst(rst), .load(accept), .start_addr(req_addr),
    .count(req_count), .step(seq_step), .addr(mem_addr),
    .last_word(last_word), .page_end(page_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      page_mode <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state     <= ST_ACCESS;
            mem_ce_n  <= 1'b0;
            mem_oe_n  <= 1'b0;
            page_mode <= page_en;
          end
        end
        ST_ACCESS: begin
          if (acc_last) begin
            rd_valid <= 1'b1;
            rd_data  <= mem_dq;
            if (last_word) begin
              state    <= ST_IDLE;
              mem_ce_n <= 1'b1;
              mem_oe_n <= 1'b1;
            end else if (!keep_open) begin
              state    <= ST_GAP;
              mem_ce_n <= 1'b1;
              mem_oe_n <= 1'b1;
            end
          end
        end
        ST_GAP: begin
          state    <= ST_ACCESS;
          mem_ce_n <= 1'b0;
          mem_oe_n <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign mem_clk   = 1'b0;
  assign mem_adv_n = 1'b0;
  assign mem_we_n  = 1'b1;
  assign mem_lb_n  = 1'b0;
  assign mem_ub_n  = 1'b0;

  // Run length of chip enable low, observed at the pin.
  logic [RW-1:0] ce_run;
  always_ff @(posedge clk) begin
    if (rst || mem_ce_n) begin
      ce_run <= '0;
    end else if (ce_run <= RW'(T_CEMAX)) begin
      ce_run <= ce_run + 1'b1;
    end
  end

  p_ce_limit_r5: assert property (@(posedge clk) disable iff (rst)
    ce_run <= RW'(T_CEMAX));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !acc_last) |=> ($stable(mem_addr) && !mem_ce_n));

  p_valid_after_sample_r2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(acc_last && !mem_ce_n));

  p_gap_single_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_ce_n) && !req_ready) |=> $fell(mem_ce_n));

  p_oe_with_ce_r8: assert property (@(posedge clk) disable iff (rst)
    mem_ce_n |-> mem_oe_n);

  p_idle_ce_high_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> mem_ce_n);
endmodule

// File: tb/psram_page_reader_bench.sv
`timescale 1ns/1ps
module psram_page_reader_bench;
  localparam int AW = 8;
  localparam int CW = 6;
  localparam int DW = 16;
  localparam int TI = 5;
  localparam int TP = 2;
  localparam int TC = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          page_en = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_count = '0;
  logic          req_ready, rd_valid;
  logic [DW-1:0] rd_data;
  logic          mem_clk, mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  psram_page_reader #(
    .ADDR_W(AW), .CNT_W(CW), .DQ_W(DW), .PAGE_W(4),
    .T_INIT(TI), .T_PAGE(TP), .T_CEMAX(TC)
  ) u_psram_page_reader (
    .clk(clk), .rst(rst), .page_en(page_en), .req_valid(req_valid),
    .req_addr(req_addr), .req_count(req_count), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_clk(mem_clk),
    .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_addr(mem_addr), .mem_dq(mem_dq)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction

  task automatic fail(input string tag, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
  endtask

  // Memory model: data is valid only after the address has been held for the
  // time its position in the chip-enable window requires.
  logic [AW-1:0] last_a;
  logic          ce_prev_low;
  int            hold, need_r, hold_c, need_c;
  logic          new_acc;

  always_comb begin
    new_acc = !ce_prev_low || (mem_addr != last_a);
    if (!ce_prev_low) need_c = TI;
    else if (new_acc) need_c = (page_en && (mem_addr[7:4] == last_a[7:4])) ? TP : TI;
    else need_c = need_r;
    hold_c = new_acc ? 1 : hold + 1;
    mem_dq = (!mem_ce_n && !mem_oe_n && hold_c >= need_c) ? pat(mem_addr) : 16'hBAD0;
  end

  always @(posedge clk) begin
    if (rst || mem_ce_n) begin
      ce_prev_low <= 1'b0;
      hold        <= 0;
      need_r      <= TI;
    end else begin
      ce_prev_low <= 1'b1;
      hold        <= hold_c;
      need_r      <= need_c;
    end
    last_a <= mem_addr;
  end

  // Pin monitor: fixed strobes and chip-enable run length.
  int ce_run = 0;
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (mem_clk !== 1'b0 || mem_adv_n !== 1'b0 || mem_we_n !== 1'b1 ||
          mem_lb_n !== 1'b0 || mem_ub_n !== 1'b0)
        fail("R7", "fixed pins", {mem_clk, mem_adv_n, mem_we_n, mem_lb_n, mem_ub_n}, 5'b00100);
      if (mem_ce_n === 1'b0) ce_run++;
      else ce_run = 0;
      if (ce_run > TC) fail("R5", "ce low run", ce_run, TC);
    end
  end

  task automatic run_req(input int a, input int n, input bit pen, input bit intrude);
    int    t_exp[64];
    int    a_exp[64];
    string why[64];
    int    t, c, k, idx;
    t = TI + 1; c = TI;
    for (int i = 0; i < n; i++) begin
      a_exp[i] = (a + i) % 256;
      if (i == 0) begin
        why[i] = "R2";
      end else if (!pen) begin
        t += 1 + TI; c = TI; why[i] = "R6";
      end else if ((a_exp[i-1] % 16) == 15) begin
        t += 1 + TI; c = TI; why[i] = "R4";
      end else if (c + TP > TC) begin
        t += 1 + TI; c = TI; why[i] = "R5";
      end else begin
        t += TP; c += TP; why[i] = "R3";
      end
      if (a_exp[i] < a_exp[0] && i > 0) why[i] = "R10";
      t_exp[i] = t;
    end
    @(negedge clk);
    checks++;
    if (req_ready !== 1'b1) fail("R9", "ready before request", req_ready, 1);
    page_en = pen; req_valid = 1'b1; req_addr = AW'(a); req_count = CW'(n);
    @(negedge clk);
    req_valid = 1'b0;
    k = 1; idx = 0;
    while (idx < n && k < 3000) begin
      if (intrude && k == 2) begin
        checks++;
        if (req_ready !== 1'b0) fail("R9", "ready while busy", req_ready, 0);
        req_valid = 1'b1; req_addr = AW'(a ^ 8'h80); req_count = CW'(3);
      end else if (intrude && k == 3) begin
        req_valid = 1'b0;
      end
      if (rd_valid || k == t_exp[idx]) begin
        checks++;
        if (rd_valid !== 1'b1 || k != t_exp[idx])
          fail(why[idx], $sformatf("word %0d arrival cycle", idx), rd_valid ? k : 0, t_exp[idx]);
        else if (rd_data !== pat(AW'(a_exp[idx])))
          fail(why[idx], $sformatf("word %0d data", idx), rd_data, pat(AW'(a_exp[idx])));
        if (idx == n - 1) begin
          checks++;
          if (mem_ce_n !== 1'b1 || mem_oe_n !== 1'b1 || req_ready !== 1'b1)
            fail("R8", "state at last word", {mem_ce_n, mem_oe_n, req_ready}, 3'b111);
        end
        idx++;
      end
      @(negedge clk);
      k++;
    end
    if (idx < n) fail("R2", "words received", idx, n);
    repeat (2) begin
      checks++;
      if (rd_valid !== 1'b0 || mem_ce_n !== 1'b1)
        fail("R9", "activity after request", {rd_valid, mem_ce_n}, 2'b01);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (mem_ce_n !== 1'b1 || mem_oe_n !== 1'b1 || rd_valid !== 1'b0 || req_ready !== 1'b1)
      fail("R1", "reset state", {mem_ce_n, mem_oe_n, rd_valid, req_ready}, 4'b1101);

    // R9: count of zero launches nothing.
    req_valid = 1'b1; req_addr = 8'h12; req_count = '0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (6) begin
      checks++;
      if (mem_ce_n !== 1'b1 || rd_valid !== 1'b0 || req_ready !== 1'b1)
        fail("R9", "zero count ignored", {mem_ce_n, rd_valid, req_ready}, 3'b101);
      @(negedge clk);
    end

    // R2 R3 R4: every start offset within two pages against many counts.
    for (int a = 0; a < 20; a++)
      for (int n = 1; n <= 12; n++)
        run_req(a, n, 1'b1, 1'b0);
    // R6: page mode off.
    for (int a = 0; a < 16; a += 7)
      for (int n = 1; n <= 5; n++)
        run_req(a, n, 1'b0, 1'b0);
    // R5: budget breaks inside a page.
    run_req(0, 16, 1'b1, 1'b0);
    run_req(3, 40, 1'b1, 1'b0);
    // R10: wrap at the top of the address space.
    run_req(250, 12, 1'b1, 1'b0);
    // R9: request offered while busy is ignored.
    run_req(33, 6, 1'b1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule